// File: doc/BRIEF.md
# Four-Point Real-Input Frequency Transform

This unit turns a block of four real signed fixed-point time samples into the four complex bins of their discrete Fourier transform. A whole block arrives in one input beat and leaves as one output beat. Because the four-point twiddle factors are only ±1 and ±j, every bin is formed from additions and subtractions alone. The datapath therefore uses no multipliers.

Both sides use a valid/ready handshake. A single output register stage sits between them. One block can be accepted every cycle, and each result appears one cycle after it is accepted. When the downstream side stalls, the register keeps its contents. Input ready falls only while that held beat cannot drain. A block-end flag travels with each beat.

Top module: `dft4_unit`

## Requirements
- R1: Bin 0 real part equals x0+x1+x2+x3, and bin 0 imaginary part is always zero.
- R2: Bin 1 real part equals x0−x2, and bin 1 imaginary part equals x3−x1.
- R3: Bin 2 real part equals (x0−x1)+(x2−x3), and bin 2 imaginary part is always zero.
- R4: Bin 3 real part equals x0−x2, and bin 3 imaginary part equals x1−x3.
- R5: Samples and results are 32-bit two's-complement values with 8 integer bits. All sums wrap modulo 2^32 with no saturation, so four samples of 0x7FFFFFFF give a bin 0 real part of 0xFFFFFFFC.
- R6: Input word packing puts x0 in bits [31:0], x1 in [63:32], x2 in [95:64] and x3 in [127:96]. Output word packing puts real parts of bins 0..3 in [31:0], [63:32], [95:64] and [127:96], then imaginary parts of bins 0..3 in [159:128], [191:160], [223:192] and [255:224].
- R7: The last flag of an accepted input beat appears on outLast with that beat's result.
- R8: A beat accepted at a clock edge is presented with outValid high right after that edge. Back-to-back beats are accepted on consecutive cycles.
- R9: While outValid is high and outReady is low, outData, outLast and outValid hold their values and inReady is low.
- R10: inReady is high whenever the output register is empty or is draining in the same cycle (outReady high). A new beat can then be captured in the same edge that hands off the old one.
- R11: After reset, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat present |
| inReady | output | 1 | Unit can take an input beat |
| inData | input | 128 | Four packed time samples |
| inLast | input | 1 | Block-end flag of input beat |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Downstream takes the output beat |
| outData | output | 256 | Four real then four imaginary bin values |
| outLast | output | 1 | Block-end flag of output beat |

## Verification
Two functions can fall in the same cycle: draining the held result and capturing a fresh block. To provoke this, the bench first stalls the output with one block held. It then presents a second block while raising outReady. At the next edge the bench requires that the held result is gone and the second block's bins are in its place, with no bubble. The steady table run also holds outReady high, so every cycle both drains and accepts. Each sampled beat there must match the block sent one edge earlier.

// File: rtl/dft4_pkg.sv
package dft4_pkg;
  localparam int POINTS = 4;

  typedef struct packed {
    logic load;     // capture a new block into the output register
    logic advance;  // output register may change this cycle
  } dftCtrl_t;
endpackage

// File: rtl/dft4_ctrl.sv
module dft4_ctrl
  import dft4_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output dftCtrl_t ctrl
);
  logic fullQ;

  assign inReady      = !fullQ || outReady;
  assign ctrl.advance = inReady;
  assign ctrl.load    = inValid && inReady;
  assign outValid     = fullQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullQ <= 1'b0;
    end else if (ctrl.advance) begin
      fullQ <= inValid;
    end
  end
endmodule

// File: rtl/dft4_datapath.sv
module dft4_datapath
  import dft4_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dftCtrl_t              ctrl,
  input  logic [POINTS*W-1:0]   inData,
  input  logic                  inLast,
  output logic [2*POINTS*W-1:0] outData,
  output logic                  outLast
);
  localparam int IMAG_BASE = POINTS * W;

  logic [W-1:0] sample [POINTS];
  logic [W-1:0] reNext [POINTS];
  logic [W-1:0] imNext [POINTS];
  logic [W-1:0] reQ    [POINTS];
  logic [W-1:0] imQ    [POINTS];
  logic         lastQ;

  for (genvar s = 0; s < POINTS; s++) begin : g_unpack
    assign sample[s] = inData[s*W +: W];
  end

  // first butterfly stage: pairs at distance two
  logic [W-1:0] sumEven, difEven, sumOdd, difOdd;
  always_comb begin
    sumEven = sample[0] + sample[2];
    difEven = sample[0] - sample[2];
    sumOdd  = sample[1] + sample[3];
    difOdd  = sample[1] - sample[3];
    reNext[0] = sumEven + sumOdd;
    imNext[0] = '0;
    reNext[1] = difEven;
    imNext[1] = '0 - difOdd;
    reNext[2] = sumEven - sumOdd;
    imNext[2] = '0;
    reNext[3] = difEven;
    imNext[3] = difOdd;
  end

  for (genvar b = 0; b < POINTS; b++) begin : g_bin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        reQ[b] <= '0;
        imQ[b] <= '0;
      end else if (ctrl.load) begin
        reQ[b] <= reNext[b];
        imQ[b] <= imNext[b];
      end
    end
    assign outData[b*W +: W]             = reQ[b];
    assign outData[IMAG_BASE + b*W +: W] = imQ[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastQ <= 1'b0;
    end else if (ctrl.load) begin
      lastQ <= inLast;
    end
  end
  assign outLast = lastQ;
endmodule

// File: rtl/dft4_unit.sv
module dft4_unit
  import dft4_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [POINTS*W-1:0]   inData,
  input  logic                  inLast,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [2*POINTS*W-1:0] outData,
  output logic                  outLast
);
  dftCtrl_t ctrl;

  dft4_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .ctrl     (ctrl)
  );

  dft4_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .inData  (inData),
    .inLast  (inLast),
    .outData (outData),
    .outLast (outLast)
  );
endmodule

// File: rtl/dft4_unit_chk.sv
module dft4_unit_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           inReady,
  input logic [4*W-1:0] inData,
  input logic           inLast,
  input logic           outValid,
  input logic           outReady,
  input logic [8*W-1:0] outData,
  input logic           outLast
);
  logic [W-1:0] x0, x1, x2, x3, allSum, oddDiff;
  assign x0 = inData[0*W +: W];
  assign x1 = inData[1*W +: W];
  assign x2 = inData[2*W +: W];
  assign x3 = inData[3*W +: W];
  assign allSum  = x0 + x1 + x2 + x3;
  assign oddDiff = x3 - x1;

  logic accept;
  assign accept = inValid && inReady;

  // R1
  bin0_real_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outData[0 +: W] == $past(allSum));

  // R2
  bin1_imag_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outData[5*W +: W] == $past(oddDiff));

  // R7
  last_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outLast == $past(inLast));

  // R8
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outValid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outData) && $stable(outLast));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R10
  ready_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid || outReady) |-> inReady);

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> !outValid);
endmodule

bind dft4_unit dft4_unit_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .inData   (inData),
  .inLast   (inLast),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .outLast  (outLast)
);

// File: tb/dft4_unit_test.sv
module dft4_unit_test;
  localparam int W = 32;
  localparam int NVEC = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           inValid = 1'b0;
  logic           inReady;
  logic [4*W-1:0] inData = '0;
  logic           inLast = 1'b0;
  logic           outValid;
  logic           outReady = 1'b0;
  logic [8*W-1:0] outData;
  logic           outLast;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dft4_unit #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLast(outLast)
  );

  // x3, x2, x1, x0 from high to low word
  localparam logic [4*W-1:0] STIM [NVEC] = '{
    {32'd4, 32'd3, 32'd2, 32'd1},
    {32'h0100_0000, 32'h0080_0000, 32'h0040_0000, 32'h0200_0000},
    {32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001},
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h1234_5678},
    {32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF},
    {32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000},
    {32'hF000_0000, 32'h0A00_0000, 32'hFD00_0000, 32'h0500_0000},
    {32'h0000_0011, 32'h0000_0022, 32'h0000_0033, 32'h0000_0044}
  };

  function automatic logic [8*W-1:0] expectBins(input logic [4*W-1:0] d);
    logic [W-1:0] a, b, c, e;
    logic [W-1:0] r0, r1, r2, r3, i0, i1, i2, i3;
    a = d[0 +: W]; b = d[W +: W]; c = d[2*W +: W]; e = d[3*W +: W];
    r0 = a + b + c + e;   i0 = '0;       // R1
    r1 = a - c;           i1 = e - b;    // R2
    r2 = (a - b) + (c - e); i2 = '0;     // R3
    r3 = a - c;           i3 = b - e;    // R4
    return {i3, i2, i1, i0, r3, r2, r1, r0}; // R6
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBins(input logic [4*W-1:0] d, input string ctx);
    logic [8*W-1:0] exp;
    string tags [4];
    tags = '{"R1", "R2", "R3", "R4"};
    exp = expectBins(d);
    for (int k = 0; k < 4; k++) begin
      check(outData[k*W +: W] == exp[k*W +: W], {tags[k], " real ", ctx},
            outData[k*W +: W], exp[k*W +: W]);
      check(outData[(4+k)*W +: W] == exp[(4+k)*W +: W], {tags[k], " imag ", ctx},
            outData[(4+k)*W +: W], exp[(4+k)*W +: W]);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // reset state, R11; R10 with empty register and outReady low
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R11 outValid in reset", W'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R11 outValid after reset", W'(outValid), 0);
    check(inReady == 1'b1, "R10 R11 inReady empty", W'(inReady), 1);

    // table walk, back-to-back with outReady high: R1-R4 bins, R7, R8
    outReady = 1'b1;
    for (int i = 0; i <= NVEC; i++) begin
      if (i > 0) begin
        check(outValid == 1'b1, "R8 back-to-back valid", W'(outValid), 1);
        check(outLast == ((i - 1) % 2 == 1), "R7 last follows", W'(outLast), W'((i - 1) % 2));
        checkBins(STIM[i-1], "table");
      end
      if (i < NVEC) begin
        inValid = 1'b1;
        inData  = STIM[i];
        inLast  = (i % 2 == 1);
      end else begin
        inValid = 1'b0;
      end
      @(negedge clk);
    end
    check(outValid == 1'b0, "R8 drained", W'(outValid), 0);

    // R5 wrap: four times 0x7FFFFFFF
    inValid = 1'b1; inData = {4{32'h7FFF_FFFF}}; inLast = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    check(outData[0 +: W] == 32'hFFFF_FFFC, "R5 wrap", outData[0 +: W], 32'hFFFF_FFFC);
    // R6 packing: distinct samples, bin1 real in [63:32], bin3 imag in [255:224]
    inValid = 1'b1; inData = {32'd40, 32'd30, 32'd20, 32'd10};
    @(negedge clk);
    inValid = 1'b0;
    check(outData[63:32] == 32'hFFFF_FFEC, "R6 bin1 real slot", outData[63:32], 32'hFFFF_FFEC);
    check(outData[255:224] == 32'hFFFF_FFEC, "R6 bin3 imag slot", outData[255:224], 32'hFFFF_FFEC);
    check(outData[191:160] == 32'd20, "R6 bin1 imag slot", outData[191:160], 32'd20);
    @(negedge clk);

    // stall: R9 hold, then R10 drain and capture in same edge
    outReady = 1'b0;
    inValid = 1'b1; inData = STIM[1]; inLast = 1'b1;
    @(negedge clk);
    check(outValid == 1'b1, "R8 stall first", W'(outValid), 1);
    check(inReady == 1'b0, "R9 inReady low", W'(inReady), 0);
    inData = STIM[6]; inLast = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(outValid == 1'b1, "R9 valid held", W'(outValid), 1);
    check(outLast == 1'b1, "R9 last held", W'(outLast), 1);
    checkBins(STIM[1], "R9 held");
    outReady = 1'b1;
    #1;
    check(inReady == 1'b1, "R10 ready while draining", W'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, "R10 swap valid", W'(outValid), 1);
    check(outLast == 1'b0, "R10 swap last", W'(outLast), 0);
    checkBins(STIM[6], "R10 swap");
    @(negedge clk);
    check(outValid == 1'b0, "R10 empty after drain", W'(outValid), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule